// File: doc/BRIEF.md
# Powered-Port Current Supervisor

This block watches a power-sourcing port after power has been granted. Each cycle it takes the measured output current in milliamps, the live output voltage in volts and the granted power class. It decides whether the port is overloaded, whether a class-4 load has kept the analog current limiter engaged too long, and whether the load has gone away. It raises a one-cycle fault pulse for either overload case and a one-cycle disconnect pulse when the load is gone. It also drives a select code that the analog limiter uses to pick its current ceiling.

The overload trip point depends on the granted power and on the present output voltage. The block does not divide to get a current threshold. It multiplies current by voltage in a registered stage and compares that product in milliwatts against the class budget. Two integrating timers run on a 1 ms tick and count up and down at different rates. The overload timer rises one step per tick and falls one step per sixteen ticks. The disconnect timer rises one step per tick and falls ten steps per tick. A short glitch therefore does not reset the accumulated history, and a brief recovery does not fully clear it.

When the powered-state enable is low, every timer and latch is cleared. Once a fault or a disconnect has been reported, the block stays silent until the enable is dropped.

Top module: `pse_current_supervisor`

## Requirements
- R1: The port counts as overloaded when current (mA) times voltage (V) is strictly greater than the class budget in mW. The budget is 7500 for class codes 1 and 2, 33200 for class code 4, and 16500 for class codes 0 and 3 and for any code above 4.
- R2: While the port is overloaded, the overload timer gains one step per tick. A fault pulse is raised on the tick that brings it to 60.
- R3: While the port is not overloaded, the overload timer loses one step on every 16th consecutive non-overloaded tick and never goes below zero. Any overloaded tick restarts this 16-tick count.
- R4: With class code 4, the limiter-active input held high on 15 consecutive ticks raises a fault pulse, and one tick with it low restarts the count. With any other class code, the limiter-active input has no effect.
- R5: The limit select output is 1 (885 mA ceiling) only when the class code is 4 and at least 5 ticks have passed since the enable rose. Otherwise it is 0 (425 mA ceiling).
- R6: While the current is below 8 mA, the disconnect timer gains one step per tick. A disconnect pulse is raised on the tick that brings it to 350.
- R7: While the current is 8 mA or more, the disconnect timer loses ten steps per tick and stops at zero.
- R8: The fault and disconnect outputs are pulses one cycle wide. After either one, no further pulse appears until the enable has been low.
- R9: While the enable is low, all timers, latches and outputs are held clear, and no pulse appears whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en_i | input | 1 | Port is in the powered state |
| tick_i | input | 1 | One-cycle 1 ms time base strobe |
| cls_i | input | 3 | Granted class code |
| cur_ma_i | input | I_W (10) | Output current in mA |
| vout_i | input | V_W (7) | Output voltage in V |
| lim_act_i | input | 1 | Analog current limiter is active |
| ilim_sel_o | output | 1 | Limit ceiling select: 0 = 425 mA, 1 = 885 mA |
| fault_o | output | 1 | Overload or limit-duration fault pulse |
| disc_o | output | 1 | Load-removed pulse |

## Verification
A wrong timer value shows at the ports as a fault or disconnect pulse that arrives one or more ticks early or late. The bench therefore checks the pulse count just before and just after the expected tick, and it places the leak-rate cases so that an error of a single step moves the trip by a whole tick. A wrong budget or compare shows as a trip at a current one milliamp off the arithmetic boundary, so each class code is swept at several voltages on both sides of that boundary. Stale state left after the enable drops shows up within the next window as a trip that comes too early.

// File: rtl/pse_sup_pkg.sv
package pse_sup_pkg;
  localparam int CLS_W       = 3;
  localparam int BUDGET_LOW  = 7500;
  localparam int BUDGET_MID  = 16500;
  localparam int BUDGET_HIGH = 33200;
  localparam logic [CLS_W-1:0] CLS_TOP = 3'd4;

  function automatic int budget_mw(input logic [CLS_W-1:0] cls);
    case (cls)
      3'd1, 3'd2: return BUDGET_LOW;
      3'd4:       return BUDGET_HIGH;
      default:    return BUDGET_MID;
    endcase
  endfunction
endpackage

// File: rtl/pse_power_cmp.sv
module pse_power_cmp
  import pse_sup_pkg::*;
#(
  parameter int I_W = 10,
  parameter int V_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [CLS_W-1:0] cls_i,
  input  logic [I_W-1:0]   cur_i,
  input  logic [V_W-1:0]   volt_i,
  output logic             over_o
);
  localparam int P_W = I_W + V_W;

  logic [P_W-1:0] prod_q;
  logic [P_W-1:0] budget_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      prod_q   <= '0;
      budget_q <= '0;
      over_o   <= 1'b0;
    end else begin
      prod_q   <= P_W'(cur_i) * P_W'(volt_i);
      budget_q <= P_W'(budget_mw(cls_i));
      over_o   <= prod_q > budget_q;
    end
  end
endmodule

// File: rtl/pse_leaky_timer.sv
module pse_leaky_timer #(
  parameter int LIMIT     = 60,
  parameter int DOWN_STEP = 1,
  parameter int DOWN_DIV  = 16,
  parameter int C_W       = $clog2(LIMIT + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           tick_i,
  input  logic           up_i,
  output logic           hit_o,
  output logic [C_W-1:0] cnt_o
);
  localparam int D_W = (DOWN_DIV > 1) ? $clog2(DOWN_DIV) : 1;

  logic dec_en;

  generate
    if (DOWN_DIV > 1) begin : g_pre
      logic [D_W-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          div_q <= '0;
        end else if (tick_i) begin
          if (up_i || div_q == D_W'(DOWN_DIV - 1)) div_q <= '0;
          else                                     div_q <= div_q + 1'b1;
        end
      end
      assign dec_en = (div_q == D_W'(DOWN_DIV - 1));
    end else begin : g_nopre
      assign dec_en = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_o <= '0;
      hit_o <= 1'b0;
    end else begin
      hit_o <= 1'b0;
      if (tick_i) begin
        if (up_i) begin
          if (cnt_o >= C_W'(LIMIT - 1)) begin
            cnt_o <= C_W'(LIMIT);
            hit_o <= 1'b1;
          end else begin
            cnt_o <= cnt_o + 1'b1;
          end
        end else if (dec_en) begin
          if (cnt_o <= C_W'(DOWN_STEP)) cnt_o <= '0;
          else                          cnt_o <= cnt_o - C_W'(DOWN_STEP);
        end
      end
    end
  end
endmodule

// File: rtl/pse_current_supervisor.sv
module pse_current_supervisor
  import pse_sup_pkg::*;
#(
  parameter int I_W       = 10,
  parameter int V_W       = 7,
  parameter int OC_MS     = 60,
  parameter int OC_DIV    = 16,
  parameter int LIM_MS    = 15,
  parameter int DISC_MS   = 350,
  parameter int DISC_STEP = 10,
  parameter int DISC_MA   = 8,
  parameter int PU_MS     = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pwr_en_i,
  input  logic           tick_i,
  input  logic [2:0]     cls_i,
  input  logic [I_W-1:0] cur_ma_i,
  input  logic [V_W-1:0] vout_i,
  input  logic           lim_act_i,
  output logic           ilim_sel_o,
  output logic           fault_o,
  output logic           disc_o
);
  localparam int OC_W   = $clog2(OC_MS + 1);
  localparam int LIM_W  = $clog2(LIM_MS + 1);
  localparam int DISC_W = $clog2(DISC_MS + 1);
  localparam int PU_W   = $clog2(PU_MS + 1);

  logic              clr;
  logic              tripped_q;
  logic              tick_run;
  logic              over;
  logic              under_q;
  logic              lim_q;
  logic              oc_hit, lim_hit, disc_hit;
  logic [OC_W-1:0]   oc_cnt;
  logic [LIM_W-1:0]  lim_cnt;
  logic [DISC_W-1:0] disc_cnt;
  logic [PU_W-1:0]   pu_cnt;

  assign clr      = ~pwr_en_i;
  assign tick_run = tick_i & ~tripped_q;

  pse_power_cmp #(.I_W(I_W), .V_W(V_W)) u_cmp (
    .clk(clk), .rst(rst), .clr(clr), .cls_i(cls_i),
    .cur_i(cur_ma_i), .volt_i(vout_i), .over_o(over)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      under_q <= 1'b0;
      lim_q   <= 1'b0;
    end else begin
      under_q <= cur_ma_i < I_W'(DISC_MA);
      lim_q   <= lim_act_i && (cls_i == CLS_TOP);
    end
  end

  pse_leaky_timer #(.LIMIT(OC_MS), .DOWN_STEP(1), .DOWN_DIV(OC_DIV), .C_W(OC_W)) u_oc (
    .clk(clk), .rst(rst), .clr(clr), .tick_i(tick_run), .up_i(over),
    .hit_o(oc_hit), .cnt_o(oc_cnt)
  );

  pse_leaky_timer #(.LIMIT(LIM_MS), .DOWN_STEP(LIM_MS), .DOWN_DIV(1), .C_W(LIM_W)) u_lim (
    .clk(clk), .rst(rst), .clr(clr), .tick_i(tick_run), .up_i(lim_q),
    .hit_o(lim_hit), .cnt_o(lim_cnt)
  );

  pse_leaky_timer #(.LIMIT(DISC_MS), .DOWN_STEP(DISC_STEP), .DOWN_DIV(1), .C_W(DISC_W)) u_disc (
    .clk(clk), .rst(rst), .clr(clr), .tick_i(tick_run), .up_i(under_q),
    .hit_o(disc_hit), .cnt_o(disc_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tripped_q  <= 1'b0;
      fault_o    <= 1'b0;
      disc_o     <= 1'b0;
      pu_cnt     <= '0;
      ilim_sel_o <= 1'b0;
    end else begin
      fault_o    <= (oc_hit | lim_hit) & ~tripped_q;
      disc_o     <= disc_hit & ~(oc_hit | lim_hit) & ~tripped_q;
      tripped_q  <= tripped_q | oc_hit | lim_hit | disc_hit;
      if (tick_i && pu_cnt != PU_W'(PU_MS)) pu_cnt <= pu_cnt + 1'b1;
      ilim_sel_o <= (cls_i == CLS_TOP) && (pu_cnt == PU_W'(PU_MS));
    end
  end
endmodule

// File: rtl/pse_sup_checker.sv
module pse_sup_checker #(
  parameter int OC_MS   = 60,
  parameter int DISC_MS = 350,
  parameter int OC_W    = $clog2(OC_MS + 1),
  parameter int DISC_W  = $clog2(DISC_MS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              pwr_en,
  input logic              tick,
  input logic [2:0]        cls,
  input logic              fault,
  input logic              disc,
  input logic              ilim_sel,
  input logic [OC_W-1:0]   oc_cnt,
  input logic [DISC_W-1:0] disc_cnt
);
  AST_OC_BOUND: assert property (@(posedge clk) disable iff (rst)
    oc_cnt <= OC_W'(OC_MS)); // R2
  AST_DISC_BOUND: assert property (@(posedge clk) disable iff (rst)
    disc_cnt <= DISC_W'(DISC_MS)); // R6
  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (rst)
    fault |=> !fault); // R8
  AST_DISC_PULSE: assert property (@(posedge clk) disable iff (rst)
    disc |=> !disc); // R8
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !pwr_en |=> (!fault && !disc && !ilim_sel)); // R9
  AST_ILIM_CLASS: assert property (@(posedge clk) disable iff (rst)
    (cls != 3'd4) |=> !ilim_sel); // R5
  AST_FAULT_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    fault |-> $past(tick, 2)); // R2
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
    !(fault && disc)); // R8
endmodule

bind pse_current_supervisor pse_sup_checker #(.OC_MS(OC_MS), .DISC_MS(DISC_MS)) u_chk (
  .clk(clk), .rst(rst), .pwr_en(pwr_en_i), .tick(tick_i), .cls(cls_i),
  .fault(fault_o), .disc(disc_o), .ilim_sel(ilim_sel_o),
  .oc_cnt(oc_cnt), .disc_cnt(disc_cnt)
);

// File: tb/pse_current_supervisor_bench.sv
module pse_current_supervisor_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_en = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] cls = 3'd0;
  logic [9:0] cur = '0;
  logic [6:0] vout = 7'd50;
  logic       lim = 1'b0;
  logic       ilim_sel, fault, disc;

  int vectors = 0;
  int miscompares = 0;
  int fcnt = 0;
  int dcnt = 0;

  always #5 clk = ~clk;

  pse_current_supervisor u_pse_current_supervisor (
    .clk(clk), .rst(rst), .pwr_en_i(pwr_en), .tick_i(tick), .cls_i(cls),
    .cur_ma_i(cur), .vout_i(vout), .lim_act_i(lim),
    .ilim_sel_o(ilim_sel), .fault_o(fault), .disc_o(disc)
  );

  always @(negedge clk) begin
    if (fault) fcnt++;
    if (disc)  dcnt++;
  end

  function automatic int bud(input int c);
    if (c == 1 || c == 2) return 7500;
    if (c == 4) return 33200;
    return 16500;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic repower();
    @(negedge clk) pwr_en = 1'b0;
    settle();
    pwr_en = 1'b1;
    settle();
    fcnt = 0;
    dcnt = 0;
  endtask

  initial begin
    #1_500_000;
    miscompares++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();
    chk("reset fault R9", int'(fault), 0);
    chk("reset disc R9", int'(disc), 0);
    chk("reset ilim R5", int'(ilim_sel), 0);

    // R1 R2 R8: boundary sweep over class codes and voltages
    for (int c = 0; c < 6; c++) begin
      for (int vi = 0; vi < 3; vi++) begin
        int v;
        int iok;
        v = (vi == 0) ? 44 : (vi == 1) ? 50 : 57;
        iok = bud(c) / v;
        cls = 3'(c);
        vout = 7'(v);
        cur = 10'(iok);
        repower();
        ticks(70);
        chk($sformatf("R1 no trip at boundary c=%0d v=%0d", c, v), fcnt, 0);
        cur = 10'(iok + 1);
        repower();
        ticks(59);
        chk($sformatf("R2 no fault at 59 c=%0d v=%0d", c, v), fcnt, 0);
        ticks(1);
        chk($sformatf("R2 fault at 60 c=%0d v=%0d", c, v), fcnt, 1);
        ticks(10);
        chk($sformatf("R8 single fault c=%0d v=%0d", c, v), fcnt, 1);
      end
    end

    // R3: slow leak, 32 under ticks remove two steps
    cls = 3'd0; vout = 7'd50; cur = 10'd331;
    repower();
    ticks(40);
    cur = 10'd300; settle(); ticks(32);
    cur = 10'd331; settle(); ticks(21);
    chk("R3 leak keeps 59", fcnt, 0);
    ticks(1);
    chk("R3 leak trip at 60", fcnt, 1);

    // R3: an overloaded tick restarts the 16-tick leak count
    repower();
    ticks(40);
    cur = 10'd300; settle(); ticks(15);
    cur = 10'd331; settle(); ticks(1);
    cur = 10'd300; settle(); ticks(15);
    cur = 10'd331; settle(); ticks(18);
    chk("R3 restart no leak 59", fcnt, 0);
    ticks(1);
    chk("R3 restart trip 60", fcnt, 1);

    // R4: limiter duration for class 4
    cls = 3'd4; cur = 10'd100; lim = 1'b1;
    repower();
    ticks(14);
    lim = 1'b0; settle(); ticks(1);
    lim = 1'b1; settle(); ticks(14);
    chk("R4 limit 14 no fault", fcnt, 0);
    ticks(1);
    chk("R4 limit 15 fault", fcnt, 1);
    cls = 3'd3;
    repower();
    ticks(40);
    chk("R4 limit ignored class 3", fcnt, 0);
    lim = 1'b0;

    // R5: limit ceiling select
    cls = 3'd4;
    repower();
    ticks(4);
    chk("R5 ilim low in transient", int'(ilim_sel), 0);
    ticks(1);
    chk("R5 ilim high after transient", int'(ilim_sel), 1);
    cls = 3'd3; settle();
    chk("R5 ilim low class 3", int'(ilim_sel), 0);
    cls = 3'd4; settle();
    chk("R5 ilim back high", int'(ilim_sel), 1);

    // R6 R8: disconnect
    cls = 3'd0; cur = 10'd0;
    repower();
    ticks(349);
    chk("R6 no disc at 349", dcnt, 0);
    ticks(1);
    chk("R6 disc at 350", dcnt, 1);
    ticks(5);
    chk("R8 single disc", dcnt, 1);

    // R7: fast recovery of the disconnect timer
    repower();
    ticks(100);
    cur = 10'd20; settle(); ticks(5);
    cur = 10'd0;  settle(); ticks(299);
    chk("R7 fast leak no disc", dcnt, 0);
    ticks(1);
    chk("R7 fast leak disc", dcnt, 1);
    repower();
    ticks(20);
    cur = 10'd8; settle(); ticks(3);
    cur = 10'd7; settle(); ticks(349);
    chk("R7 floor no disc", dcnt, 0);
    ticks(1);
    chk("R7 floor disc", dcnt, 1);

    // R9: enable low clears history and blocks pulses
    cur = 10'd331;
    repower();
    ticks(50);
    repower();
    ticks(59);
    chk("R9 cleared no fault", fcnt, 0);
    ticks(1);
    chk("R9 cleared fault", fcnt, 1);
    @(negedge clk) pwr_en = 1'b0;
    cur = 10'd0; fcnt = 0; dcnt = 0;
    ticks(400);
    chk("R9 off no disc", dcnt, 0);
    chk("R9 off no fault", fcnt, 0);
    chk("R9 off ilim", int'(ilim_sel), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule